// File: doc/BRIEF.md
# Pixel Timing Switch-State Latch

This block holds the fast, per-pixel control word for a two-channel CCD video processor. A timing source writes a word onto a backplane data bus and pulses a write strobe. The block takes the word only when its timing-address field equals the board's 4-bit jumper setting. The latched bits then drive the analog switch controls of both video channels with identical timing: integrator reset, DC restore, inverting and non-inverting polarity select, and integrate enable. These five controls are active low, so a 0 closes the switch.

Two further latched bits are edge strobes. A rising edge on the start bit begins an A/D conversion. A rising edge on the transfer bit copies each channel's 16-bit converter result into a holding latch, where it waits for backplane readout. A new word may be written on every clock, so the fastest pixel sequences (about 40 ns per switch step) are possible. A conflict flag goes high whenever the held state closes both polarity switches together, or closes integrate and integrator reset together.

Top module: `pix_switch_latch`

## Requirements
- R1: After synchronous reset, all five active-low controls are 1 on both channels, the start and transfer strobes are 0, both holding latches read 0, and the conflict flag is 0.
- R2: When `wr_stb` is 1 at a clock edge and `bus_word[11:8]` equals `jumper_addr`, each output shows `bus_word[6:0]` from the next edge on. The bit order is: bit 0 integrator reset, bit 1 DC restore, bit 2 inverting polarity, bit 3 non-inverting polarity, bit 4 integrate, bit 5 A/D start, bit 6 A/D transfer. Bit 7 is ignored.
- R3: A strobed write whose address field differs from `jumper_addr` leaves every output unchanged. So does a clock with `wr_stb` at 0.
- R4: Channel 0 and channel 1 always carry the same switch and strobe levels.
- R5: On the edge where the transfer output rises from 0 to 1, each channel's holding latch takes that channel's `adc_raw` slice as present at that edge.
- R6: The holding latches do not change while transfer stays high (even across rewrites), when transfer falls, or while transfer stays low.
- R7: `conflict` is 1 exactly while both polarity controls are 0.
- R8: `conflict` is 1 exactly while integrate and integrator reset are both 0 (combined by OR with R7).
- R9: Writes on consecutive clocks each take effect, one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jumper_addr | input | 4 | Board timing-address jumper value |
| wr_stb | input | 1 | Switch-state write strobe |
| bus_word | input | 12 | Backplane word: [11:8] address, [6:0] state |
| adc_raw | input | 32 | Converter outputs, channel n at [16n+15:16n] |
| int_rst_n | output | 2 | Integrator reset, active low, per channel |
| dc_rest_n | output | 2 | DC restore, active low, per channel |
| pol_inv_n | output | 2 | Inverting polarity select, active low |
| pol_non_n | output | 2 | Non-inverting polarity select, active low |
| integ_n | output | 2 | Integrate enable, active low |
| adc_start | output | 2 | A/D start strobe |
| adc_xfer | output | 2 | A/D transfer strobe |
| adc_hold | output | 32 | Held converter results, same slicing as adc_raw |
| conflict | output | 1 | Switch conflict flag |

## Verification
The bench builds the block with its defaults: a 4-bit address, a 12-bit bus word, two channels and 16-bit results. The jumper input is moved between 5 and 0, so both the default zero address and a nonzero match are exercised. Converter data is modelled as a counter that changes every cycle, with a different pattern on each channel. A capture from the wrong edge, or from the wrong channel slice, therefore shows up as a value mismatch. Random writes, with about a quarter of them to foreign addresses, reach held-high and falling transfer levels, back-to-back rewrites and every conflict combination.

// File: rtl/pix_sw_pkg.sv
// Package: bit positions of the switch-state word and shared helpers.
// Assumes a 7-bit state field at the bottom of the bus word.
package pix_sw_pkg;
    localparam int SW_BITS   = 7;
    localparam int B_RST     = 0;
    localparam int B_DCR     = 1;
    localparam int B_POLINV  = 2;
    localparam int B_POLNON  = 3;
    localparam int B_INTEG   = 4;
    localparam int B_START   = 5;
    localparam int B_XFER    = 6;

    typedef logic [SW_BITS-1:0] sw_word_t;

    // All switches open, strobes low.
    localparam sw_word_t SW_IDLE = 7'b001_1111;

    // True when the state closes conflicting switch pairs.
    function automatic logic sw_conflict(input sw_word_t w);
        return (!w[B_POLINV] && !w[B_POLNON]) || (!w[B_INTEG] && !w[B_RST]);
    endfunction
endpackage

// File: rtl/psl_addr_match.sv
// Address decoder: qualifies the write strobe with the timing-address field.
// Assumes the address sits in the top ADDR_W bits of the bus word.
module psl_addr_match #(
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 12
) (
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] jumper_addr,
    input  logic [BUS_W-1:0]  bus_word,
    output logic              load,
    output pix_sw_pkg::sw_word_t next_word
);
    localparam int ADDR_LSB = BUS_W - ADDR_W;

    // Decode the address match and slice the state field.
    always_comb begin
        load      = wr_stb && (bus_word[BUS_W-1:ADDR_LSB] == jumper_addr);
        next_word = bus_word[pix_sw_pkg::SW_BITS-1:0];
    end
endmodule

// File: rtl/psl_state_reg.sv
// Switch-state register: holds the control word and flags transfer rising edges.
// Assumes synchronous active-low reset; one write may land per clock.
module psl_state_reg (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  pix_sw_pkg::sw_word_t next_word,
    output pix_sw_pkg::sw_word_t state,
    output logic                 cap_en
);
    import pix_sw_pkg::*;

    // Register the state word on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SW_IDLE;
        else if (load) state <= next_word;
    end

    // Capture fires in the same edge that raises the transfer bit.
    always_comb cap_en = load && next_word[B_XFER] && !state[B_XFER];

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == $past(next_word)); // R2
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(state)); // R3
endmodule

// File: rtl/psl_capture.sv
// Result holding latch for one channel, loaded when the transfer strobe rises.
// Assumes converter data is stable around the capturing edge.
module psl_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              xfer,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] hold
);
    // Latch converter data on a transfer rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold <= '0;
        else if (cap_en) hold <= raw;
    end

    AST_HOLD_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold) |-> $rose(xfer)); // R6
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer) |-> hold == $past(raw)); // R5
endmodule

// File: rtl/pix_switch_latch.sv
// Top: fast per-pixel switch-state latch for a multi-channel video processor.
// Fans the shared state to every channel, keeps per-channel result latches
// and flags conflicting switch closures. Assumes synchronous active-low reset.
module pix_switch_latch #(
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 12,
    parameter int CH     = 2,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    jumper_addr,
    input  logic                 wr_stb,
    input  logic [BUS_W-1:0]     bus_word,
    input  logic [CH*DATA_W-1:0] adc_raw,
    output logic [CH-1:0]        int_rst_n,
    output logic [CH-1:0]        dc_rest_n,
    output logic [CH-1:0]        pol_inv_n,
    output logic [CH-1:0]        pol_non_n,
    output logic [CH-1:0]        integ_n,
    output logic [CH-1:0]        adc_start,
    output logic [CH-1:0]        adc_xfer,
    output logic [CH*DATA_W-1:0] adc_hold,
    output logic                 conflict
);
    import pix_sw_pkg::*;

    logic     load;
    logic     cap_en;
    sw_word_t next_word;
    sw_word_t state;

    psl_addr_match #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) i_match (
        .wr_stb(wr_stb), .jumper_addr(jumper_addr), .bus_word(bus_word),
        .load(load), .next_word(next_word)
    );

    psl_state_reg i_state (
        .clk(clk), .rst_n(rst_n), .load(load), .next_word(next_word),
        .state(state), .cap_en(cap_en)
    );

    for (genvar c = 0; c < CH; c++) begin : g_ch
        // Drive this channel's switch controls from the shared state.
        always_comb begin
            int_rst_n[c] = state[B_RST];
            dc_rest_n[c] = state[B_DCR];
            pol_inv_n[c] = state[B_POLINV];
            pol_non_n[c] = state[B_POLNON];
            integ_n[c]   = state[B_INTEG];
            adc_start[c] = state[B_START];
            adc_xfer[c]  = state[B_XFER];
        end

        psl_capture #(.DATA_W(DATA_W)) i_cap (
            .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .xfer(state[B_XFER]),
            .raw(adc_raw[c*DATA_W +: DATA_W]),
            .hold(adc_hold[c*DATA_W +: DATA_W])
        );
    end

    // Flag conflicting switch closures in the held state.
    always_comb conflict = sw_conflict(state);

    AST_POL_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_inv_n[0] && !pol_non_n[0]) |-> conflict); // R7
    AST_INTEG_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (!integ_n[0] && !int_rst_n[0]) |-> conflict); // R8
    AST_CH_ALIKE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst_n[CH-1] == int_rst_n[0]) && (adc_xfer[CH-1] == adc_xfer[0])
        && (integ_n[CH-1] == integ_n[0])); // R4
endmodule

// File: tb/test_pix_switch_latch.sv
module test_pix_switch_latch;
    localparam int CH = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    jumper_addr = 4'd5;
    logic          wr_stb = 1'b0;
    logic [11:0]   bus_word = '0;
    logic [CH*DW-1:0] adc_raw = '0;
    logic [CH-1:0] int_rst_n, dc_rest_n, pol_inv_n, pol_non_n, integ_n, adc_start, adc_xfer;
    logic [CH*DW-1:0] adc_hold;
    logic          conflict;

    int vectors = 0;
    int fails = 0;
    logic [6:0]   exp_st = 7'b001_1111;
    logic [CH*DW-1:0] exp_hold = '0;
    logic [15:0]  cnt = 16'h0100;
    bit           done = 0;

    pix_switch_latch i_pix_switch_latch (
        .clk(clk), .rst_n(rst_n), .jumper_addr(jumper_addr), .wr_stb(wr_stb),
        .bus_word(bus_word), .adc_raw(adc_raw), .int_rst_n(int_rst_n),
        .dc_rest_n(dc_rest_n), .pol_inv_n(pol_inv_n), .pol_non_n(pol_non_n),
        .integ_n(integ_n), .adc_start(adc_start), .adc_xfer(adc_xfer),
        .adc_hold(adc_hold), .conflict(conflict)
    );

    always #4 clk = ~clk;

    function automatic logic exp_conflict(input logic [6:0] s);
        return (!s[2] && !s[3]) || (!s[4] && !s[0]);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Compare every output against the model (called at a falling edge).
    task automatic check_all(input string tag);
        for (int c = 0; c < CH; c++) begin
            check({tag, " R2/R4 switches"},
                  {57'd0, adc_xfer[c], adc_start[c], integ_n[c], pol_non_n[c],
                   pol_inv_n[c], dc_rest_n[c], int_rst_n[c]}, {57'd0, exp_st});
        end
        check({tag, " R5/R6 hold"}, {32'd0, adc_hold}, {32'd0, exp_hold});
        check({tag, " R7/R8 conflict"}, {63'd0, conflict}, {63'd0, exp_conflict(exp_st)});
    endtask

    // At a falling edge: new converter data, drive bus, update model for next edge.
    task automatic step(input logic wr, input logic [3:0] addr, input logic [6:0] st);
        cnt = cnt + 16'd3;
        adc_raw = {cnt ^ 16'hA5A5, cnt};
        wr_stb = wr;
        bus_word = {addr, 1'b1, st};
        if (wr && addr == jumper_addr) begin
            if (st[6] && !exp_st[6]) exp_hold = adc_raw;
            exp_st = st;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");
        // R3 foreign address ignored
        step(1'b1, 4'd6, 7'b100_0000); check_all("R3 foreign");
        step(1'b0, 4'd5, 7'b100_0000); check_all("R3 no strobe");
        // R5 transfer rise captures
        step(1'b1, 4'd5, 7'b101_1111); check_all("R5 rise");
        // R6 rewrite with transfer high: no capture
        step(1'b1, 4'd5, 7'b111_1111); check_all("R6 held high");
        step(1'b1, 4'd5, 7'b001_1111); check_all("R6 fall");
        // R7 and R8 conflicts
        step(1'b1, 4'd5, 7'b001_0011); check_all("R7 pol");
        step(1'b1, 4'd5, 7'b000_1110); check_all("R8 integ");
        // R9 back-to-back writes
        step(1'b1, 4'd5, 7'b000_0110);
        check_all("R9 b2b 1");
        step(1'b1, 4'd5, 7'b110_1010);
        check_all("R9 b2b 2");
        // Move jumper to default 0
        jumper_addr = 4'd0;
        step(1'b1, 4'd5, 7'b000_0000); check_all("R3 old addr");
        step(1'b1, 4'd0, 7'b000_0000); check_all("R2 addr0");
        for (int i = 0; i < 3000; i++) begin
            logic wr;
            logic [3:0] a;
            wr = ($urandom % 2) == 0;
            a = (($urandom % 4) == 0) ? 4'($urandom) : jumper_addr;
            if (i == 1500) jumper_addr = 4'd5;
            step(wr, a, 7'($urandom));
            check_all("R2/R3/R5/R6 random");
        end
        done = 1;
    end

    initial begin
        process::self().srandom(32'd1234);
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                vectors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule